// File: doc/BRIEF.md
# Keyed Write Guard for Pin Function Select

This block holds the per-pin function select vector of one I/O port and shields a fixed subset of its bits against accidental change. A select bit of 1 hands the pin to its peripheral, and a select bit of 0 leaves the pin under general-purpose control. The protected subset is a per-port constant. On a typical port it covers the debug pins, so that a stray write cannot take the debug link away.

A protected select bit changes only when two conditions hold. First, a key register must have been unlocked by writing a 32-bit magic value. Second, that bit's own entry in a commit register must be 1. Unprotected select bits take every write. The commit register can be written only while the key register is unlocked. Its entries for unprotected pins are fixed at 1.

Software uses the block through a single write port and a combinational read port that share one 2-bit register code. The committed select vector drives the pin multiplexer, which lies outside this block.

Top module: `pinsel_guard`

## Requirements
- R1: After reset, the lock register reads 1 (locked), the commit register reads 1 for unprotected bits and 0 for protected bits, and the select register and `sel_o` both equal the parameter `SEL_RST`.
- R2: A write to the select register (code 0) stores the written value into every unprotected bit, whatever the state of the lock and commit registers.
- R3: A protected select bit keeps its value on a select write while the lock register is locked, even when its commit bit is 1.
- R4: A protected select bit keeps its value on a select write while unlocked when its commit bit is 0.
- R5: A protected select bit takes the written value when the lock register is unlocked and its commit bit is 1 at the time of the write.
- R6: A write of exactly `UNLOCK_KEY` to the lock register (code 1) unlocks it, and the lock register then reads 0. A write of any other value locks it, and it then reads 1.
- R7: A write to the commit register (code 2) while locked leaves every commit bit unchanged. While unlocked, the write stores into the protected commit bits.
- R8: Commit bits at unprotected positions always read 1 and cannot be cleared, even by an unlocked commit write.
- R9: Read codes are 0 = select, 1 = lock, 2 = commit, and 3 = unused, which reads 0. Read data is zero-extended to 32 bits, and `sel_o` always equals the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 2 | Register code for the write |
| wr_data | input | 32 | Write data |
| rd_reg | input | 2 | Register code for the read |
| rd_data | output | 32 | Combinational read data |
| sel_o | output | WIDTH | Committed function select, 1 = peripheral |

## Verification
On every cycle, the assertions check that a protected select bit moves only after a select write made while unlocked with its commit bit set. They also check that unprotected bits follow each select write, that the lock opens only on the key, and that commit bits move only on unlocked commit writes. The bench's scenarios are needed for what the assertions cannot show. These include a commit bit set during one unlock and left set after relocking, a near-miss key, a commit write trying to clear unprotected positions, and the register map as seen through the read port.

// File: rtl/pinsel_guard_pkg.sv
package pinsel_guard_pkg;
   typedef enum logic [1:0] {
      RC_SEL    = 2'd0,
      RC_LOCK   = 2'd1,
      RC_COMMIT = 2'd2,
      RC_NONE   = 2'd3
   } reg_code_e;
endpackage

// File: rtl/pinsel_guard_key.sv
module pinsel_guard_key #(
   parameter logic [31:0] UNLOCK_KEY = 32'hA5C3_0F1E
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hit,
   input  logic [31:0] wr_data,
   output logic        unlocked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         unlocked <= 1'b0;
      else if (wr_hit)
         unlocked <= (wr_data == UNLOCK_KEY);
   end
endmodule

// File: rtl/pinsel_guard_commit.sv
module pinsel_guard_commit #(
   parameter int                 WIDTH     = 8,
   parameter logic [WIDTH-1:0]   PROT_MASK = 8'h8F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic             unlocked,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] commit
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (PROT_MASK[i]) begin : g_prot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               commit[i] <= 1'b0;
            else if (wr_hit && unlocked)
               commit[i] <= wr_data[i];
         end
      end else begin : g_free
         assign commit[i] = 1'b1;
      end
   end
endmodule

// File: rtl/pinsel_guard_sel.sv
module pinsel_guard_sel #(
   parameter int                 WIDTH     = 8,
   parameter logic [WIDTH-1:0]   PROT_MASK = 8'h8F,
   parameter logic [WIDTH-1:0]   SEL_RST   = 8'h8F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic             unlocked,
   input  logic [WIDTH-1:0] commit,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] sel_q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic take;
      if (PROT_MASK[i]) begin : g_prot
         assign take = wr_hit && unlocked && commit[i];
      end else begin : g_free
         assign take = wr_hit;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q[i] <= SEL_RST[i];
         else if (take)
            sel_q[i] <= wr_data[i];
      end
   end
endmodule

// File: rtl/pinsel_guard.sv
module pinsel_guard
   import pinsel_guard_pkg::*;
#(
   parameter int                 WIDTH      = 8,
   parameter logic [WIDTH-1:0]   PROT_MASK  = 8'h8F,
   parameter logic [WIDTH-1:0]   SEL_RST    = 8'h8F,
   parameter logic [31:0]        UNLOCK_KEY = 32'hA5C3_0F1E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_reg,
   input  logic [31:0]      wr_data,
   input  logic [1:0]       rd_reg,
   output logic [31:0]      rd_data,
   output logic [WIDTH-1:0] sel_o
);
   localparam int PAD = 32 - WIDTH;

   if (WIDTH < 1 || WIDTH > 31) begin : g_bad_width
      $error("pinsel_guard: WIDTH must lie in 1..31");
   end
   if (UNLOCK_KEY == 32'd0) begin : g_bad_key
      $error("pinsel_guard: UNLOCK_KEY must be nonzero");
   end

   logic             unlocked;
   logic [WIDTH-1:0] commit_q;
   logic             hit_sel, hit_lock, hit_commit;

   assign hit_sel    = wr_en && (reg_code_e'(wr_reg) == RC_SEL);
   assign hit_lock   = wr_en && (reg_code_e'(wr_reg) == RC_LOCK);
   assign hit_commit = wr_en && (reg_code_e'(wr_reg) == RC_COMMIT);

   pinsel_guard_key #(.UNLOCK_KEY(UNLOCK_KEY)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (hit_lock),
      .wr_data  (wr_data),
      .unlocked (unlocked)
   );

   pinsel_guard_commit #(.WIDTH(WIDTH), .PROT_MASK(PROT_MASK)) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (hit_commit),
      .unlocked (unlocked),
      .wr_data  (wr_data[WIDTH-1:0]),
      .commit   (commit_q)
   );

   pinsel_guard_sel #(.WIDTH(WIDTH), .PROT_MASK(PROT_MASK), .SEL_RST(SEL_RST)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (hit_sel),
      .unlocked (unlocked),
      .commit   (commit_q),
      .wr_data  (wr_data[WIDTH-1:0]),
      .sel_q    (sel_o)
   );

   always_comb begin
      unique case (reg_code_e'(rd_reg))
         RC_SEL:    rd_data = {{PAD{1'b0}}, sel_o};
         RC_LOCK:   rd_data = {31'd0, ~unlocked};
         RC_COMMIT: rd_data = {{PAD{1'b0}}, commit_q};
         default:   rd_data = 32'd0;
      endcase
   end
endmodule

// File: rtl/pinsel_guard_chk.sv
module pinsel_guard_chk #(
   parameter int                 WIDTH      = 8,
   parameter logic [WIDTH-1:0]   PROT_MASK  = 8'h8F,
   parameter logic [31:0]        UNLOCK_KEY = 32'hA5C3_0F1E
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_reg,
   input logic [31:0]      wr_data,
   input logic             unlocked,
   input logic [WIDTH-1:0] commit,
   input logic [WIDTH-1:0] sel_o
);
   logic wsel, wlock, wcom;
   assign wsel  = wr_en && wr_reg == 2'd0;
   assign wlock = wr_en && wr_reg == 2'd1;
   assign wcom  = wr_en && wr_reg == 2'd2;

   // R3 R4 R5
   prot_sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_o ^ $past(sel_o)) & PROT_MASK &
       ~($past({WIDTH{wsel && unlocked}}) & $past(commit))) == '0);

   // R2
   free_sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wsel |=> ((sel_o & ~PROT_MASK) == ($past(wr_data[WIDTH-1:0]) & ~PROT_MASK)));

   // R6
   unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wlock && wr_data == UNLOCK_KEY));

   // R6
   relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wlock && wr_data != UNLOCK_KEY) |=> !unlocked);

   // R7
   commit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit != $past(commit)) |-> $past(wcom && unlocked));

   // R8
   commit_free_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit | PROT_MASK) == '1);
endmodule

bind pinsel_guard pinsel_guard_chk #(
   .WIDTH(WIDTH), .PROT_MASK(PROT_MASK), .UNLOCK_KEY(UNLOCK_KEY)
) u_pinsel_guard_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_reg   (wr_reg),
   .wr_data  (wr_data),
   .unlocked (unlocked),
   .commit   (commit_q),
   .sel_o    (sel_o)
);

// File: tb/pinsel_guard_bench.sv
module pinsel_guard_bench;
   localparam logic [31:0] KEY = 32'hA5C3_0F1E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_reg = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [1:0]  rd_reg = 2'd0;
   logic [31:0] rd_data;
   logic [7:0]  sel_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] exp_q[$];
   bit          out_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   pinsel_guard u_pinsel_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg),
      .wr_data(wr_data), .rd_reg(rd_reg), .rd_data(rd_data), .sel_o(sel_o)
   );

   task automatic wr(input logic [1:0] code, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_reg = code; wr_data = data;
   endtask

   task automatic rd(input bit is_out, input logic [1:0] code,
                     input logic [31:0] exp, input string tag);
      @(negedge clk);
      wr_en = 1'b0; rd_reg = code;
      exp_q.push_back(exp); out_q.push_back(is_out); tag_q.push_back(tag);
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [31:0] e, a;
            bit o;
            string t;
            e = exp_q.pop_front(); o = out_q.pop_front(); t = tag_q.pop_front();
            a = o ? {24'd0, sel_o} : rd_data;
            checks++;
            if (a !== e) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", t, a, e);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(0, 2'd1, 32'h1,  "R1");
      rd(0, 2'd2, 32'h70, "R1");
      rd(0, 2'd0, 32'h8F, "R1");
      rd(1, 2'd0, 32'h8F, "R1");
      // R9 unused code
      rd(0, 2'd3, 32'h0,  "R9");
      // R2 unprotected bits follow while locked
      wr(2'd0, 32'hFFFF_FF00);
      rd(1, 2'd0, 32'h8F, "R2");
      wr(2'd0, 32'h70);
      rd(1, 2'd0, 32'hFF, "R2");
      rd(0, 2'd0, 32'hFF, "R9");
      // R7 commit write while locked ignored
      wr(2'd2, 32'hFF);
      rd(0, 2'd2, 32'h70, "R7");
      // R3 locked, commit 0
      wr(2'd0, 32'h00);
      rd(1, 2'd0, 32'h8F, "R3");
      // R6 unlock
      wr(2'd1, KEY);
      rd(0, 2'd1, 32'h0, "R6");
      // R4 unlocked, commit 0
      wr(2'd0, 32'h70);
      wr(2'd0, 32'h00);
      rd(1, 2'd0, 32'h8F, "R4");
      // R7 unlocked commit write
      wr(2'd2, 32'h01);
      rd(0, 2'd2, 32'h71, "R7");
      // R5 committed bit stored
      wr(2'd0, 32'h00);
      rd(1, 2'd0, 32'h8E, "R5");
      // R6 relock on wrong value
      wr(2'd1, 32'h1234);
      rd(0, 2'd1, 32'h1, "R6");
      // R3 commit still 1 but locked
      wr(2'd0, 32'h01);
      rd(1, 2'd0, 32'h8E, "R3");
      wr(2'd2, 32'h00);
      rd(0, 2'd2, 32'h71, "R7");
      // R6 near-miss key
      wr(2'd1, KEY ^ 32'h1);
      rd(0, 2'd1, 32'h1, "R6");
      // R5 all protected committed
      wr(2'd1, KEY);
      wr(2'd2, 32'h8F);
      rd(0, 2'd2, 32'hFF, "R7");
      wr(2'd0, 32'h00);
      rd(1, 2'd0, 32'h00, "R5");
      wr(2'd0, 32'h8A);
      rd(0, 2'd0, 32'h8A, "R5");
      // R8 unprotected commit bits stay 1
      wr(2'd2, 32'h00);
      rd(0, 2'd2, 32'h70, "R8");
      rd(0, 2'd3, 32'h0, "R9");
      repeat (3) @(negedge clk);
      done = 1'b1;
      report();
   end
endmodule